// File: doc/BRIEF.md
# Two-Way Cache Way Predictor

This block sits ahead of a two-way set-associative data cache and tells the cache which way's tag and data memories to switch on for each load or store. It keeps a small fully associative buffer of recently stored tags. Next to each tag it holds a two-bit presence mask that records the cache ways known to hold that tag. When a lookup finds its tag in the buffer with exactly one presence bit set, only that way is enabled. In every other case both ways are enabled, which is always safe.

The block has two ports. The lookup port takes the access tag and drives one enable per way. The enables are purely combinational, so they are available in the same cycle as the tag. The update port takes a tag and the way where the cache has just placed it. On an update, a tag already in the buffer gains a presence bit. A tag that is not in the buffer takes an entry.

The entry for a new tag is chosen by a small allocation controller with two states. `AL_FILL` is entered on reset, and while it is active a new tag goes into the lowest-numbered free entry. The transition "last free entry filled" moves the controller to `AL_ROTATE`. From then on, victims come from a wrapping round-robin pointer. Only reset leaves `AL_ROTATE`. The pointer advances on every allocation, in both states.

Each update falls into one of five kinds:
- `UPD_IDLE`: no update this cycle.
- `UPD_KEEP`: the tag and way are already recorded.
- `UPD_MERGE`: the tag is present and a new way bit is set.
- `UPD_FILL`: the tag takes a free entry.
- `UPD_EVICT`: the tag replaces the round-robin victim.

Top module: `way_predictor`

## Requirements
- R1: The presence mask uses bit 1 for way 0 and bit 0 for way 1. A lookup that hits an entry with mask 2'b10 drives `en_way0`=1 and `en_way1`=0.
- R2: A lookup that hits an entry with mask 2'b01 drives `en_way0`=0 and `en_way1`=1.
- R3: A lookup that hits an entry with mask 2'b11 drives both enables high.
- R4: A lookup whose tag is not held in a valid entry drives both enables high. An invalid entry never matches.
- R5: An update (`up_valid`=1) with a tag not in the buffer stores the tag in an entry and sets only the bit for `up_way` (0 = way 0, 1 = way 1).
- R6: An update with a buffered tag whose bit for `up_way` is clear sets that bit and keeps the other bit. A tag reported in both ways reads back as 2'b11.
- R7: An update whose tag and way are already recorded changes nothing. In particular it consumes no entry and does not advance the round-robin pointer.
- R8: The buffer has 8 entries. A synchronous reset (`rst_n`=0 at a clock edge) invalidates all of them, so every lookup afterwards enables both ways.
- R9: A new tag takes the lowest free entry while one exists. When all entries are valid, the victim is the entry at a 3-bit round-robin pointer. The pointer starts at 0 on reset and advances by one, wrapping, on every allocation.
- R10: Lookup enables are combinational from `lk_tag`. A lookup in the same cycle as an update sees the buffer as it was before that update, and the update becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_tag | input | TAG_W | Tag of the access being looked up |
| en_way0 | output | 1 | Enable for way 0 tag and data memories |
| en_way1 | output | 1 | Enable for way 1 tag and data memories |
| up_valid | input | 1 | Update strobe |
| up_tag | input | TAG_W | Tag that the cache has stored |
| up_way | input | 1 | Way where the cache stored `up_tag` |

## Verification
A lookup and an update can fall in the same cycle, and the lookup may even carry the very tag being written or merged. The bench provokes this in directed steps. In one step a fresh tag is looked up while it is being allocated. In another, a one-way tag is looked up while its second way is being merged in. Judging is done against a reference model. The model computes each expected enable pair from its state before applying that cycle's update, so a design that forwards the update early shows up as a mismatch. The random phase then mixes lookups and updates freely over a small tag pool, so collisions with eviction happen as well.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // Presence mask: bit 1 = way 0, bit 0 = way 1
    typedef logic [1:0] way_rec_t;

    localparam way_rec_t REC_NONE = 2'b00;
    localparam way_rec_t REC_WAY0 = 2'b10;
    localparam way_rec_t REC_WAY1 = 2'b01;
    localparam way_rec_t REC_BOTH = 2'b11;

    typedef enum logic [2:0] {
        UPD_IDLE,
        UPD_KEEP,
        UPD_MERGE,
        UPD_FILL,
        UPD_EVICT
    } upd_kind_e;

    typedef enum logic {
        AL_FILL,
        AL_ROTATE
    } alloc_state_e;

    function automatic way_rec_t way_bit(input logic way);
        return way ? REC_WAY1 : REC_WAY0;
    endfunction

endpackage

// File: rtl/wp_match.sv
module wp_match #(
    parameter int N  = 8,
    parameter int TW = 20,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [TW-1:0]         key,
    input  logic [N-1:0][TW-1:0]  tags,
    input  logic [N-1:0]          vld,
    output logic                  hit,
    output logic [IW-1:0]         idx
);

    logic [N-1:0] hit_vec;

    // one comparator per entry; invalid entries are masked out
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == key);
    end

    assign hit = |hit_vec;

    // a tag lives in at most one entry, so OR-ing indices is enough
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                idx = idx | IW'(i);
            end
        end
    end

endmodule

// File: rtl/wp_alloc.sv
module wp_alloc
    import wp_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  vld,
    input  logic          alloc,
    output logic [IW-1:0] victim,
    output logic [IW-1:0] ptr_o,
    output logic          full
);

    alloc_state_e  state_q, state_nx;
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] free_idx;
    logic          free_found;
    logic          last_free;

    // lowest-numbered free entry
    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!vld[i] && !free_found) begin
                free_idx   = IW'(i);
                free_found = 1'b1;
            end
        end
    end

    assign last_free = ($countones(~vld) == 1);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            AL_FILL:   state_nx = (alloc && last_free) ? AL_ROTATE : AL_FILL;
            AL_ROTATE: state_nx = AL_ROTATE;
            default:   state_nx = AL_FILL;
        endcase
    end

    // state register and round-robin pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AL_FILL;
            ptr_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (alloc) begin
                ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // outputs by state
    always_comb begin
        victim = free_idx;
        full   = 1'b0;
        unique case (state_q)
            AL_FILL: begin
                victim = free_idx;
                full   = 1'b0;
            end
            AL_ROTATE: begin
                victim = ptr_q;
                full   = 1'b1;
            end
            default: begin
                victim = free_idx;
                full   = 1'b0;
            end
        endcase
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/way_predictor.sv
module way_predictor
    import wp_pkg::*;
#(
    parameter int TAG_W   = 20,
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             en_way0,
    output logic             en_way1,
    input  logic             up_valid,
    input  logic [TAG_W-1:0] up_tag,
    input  logic             up_way
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
    logic [ENTRIES-1:0][1:0]       rec_q;
    logic [ENTRIES-1:0]            vld_q;

    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic             up_hit;
    logic [IDX_W-1:0] up_idx;
    logic [IDX_W-1:0] victim;
    logic [IDX_W-1:0] alloc_ptr;
    logic             full;
    logic             alloc;
    way_rec_t         lk_rec;
    way_rec_t         up_bit;
    upd_kind_e        upd_kind;

    wp_match #(.N(ENTRIES), .TW(TAG_W), .IW(IDX_W)) u_lk_match (
        .key  (lk_tag),
        .tags (tag_q),
        .vld  (vld_q),
        .hit  (lk_hit),
        .idx  (lk_idx)
    );

    wp_match #(.N(ENTRIES), .TW(TAG_W), .IW(IDX_W)) u_up_match (
        .key  (up_tag),
        .tags (tag_q),
        .vld  (vld_q),
        .hit  (up_hit),
        .idx  (up_idx)
    );

    wp_alloc #(.N(ENTRIES), .IW(IDX_W)) u_alloc (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld    (vld_q),
        .alloc  (alloc),
        .victim (victim),
        .ptr_o  (alloc_ptr),
        .full   (full)
    );

    // lookup: enable outputs from the pre-update state
    assign lk_rec = rec_q[lk_idx];

    always_comb begin
        en_way0 = 1'b1;
        en_way1 = 1'b1;
        if (lk_hit) begin
            unique case (lk_rec)
                REC_WAY0: begin
                    en_way0 = 1'b1;
                    en_way1 = 1'b0;
                end
                REC_WAY1: begin
                    en_way0 = 1'b0;
                    en_way1 = 1'b1;
                end
                default: begin
                    en_way0 = 1'b1;
                    en_way1 = 1'b1;
                end
            endcase
        end
    end

    // update classification
    assign up_bit = way_bit(up_way);

    always_comb begin
        if (!up_valid) begin
            upd_kind = UPD_IDLE;
        end else if (up_hit) begin
            upd_kind = ((rec_q[up_idx] & up_bit) != REC_NONE) ? UPD_KEEP : UPD_MERGE;
        end else begin
            upd_kind = full ? UPD_EVICT : UPD_FILL;
        end
    end

    assign alloc = (upd_kind == UPD_FILL) || (upd_kind == UPD_EVICT);

    // record storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            unique case (upd_kind)
                UPD_MERGE: begin
                    rec_q[up_idx] <= rec_q[up_idx] | up_bit;
                end
                UPD_FILL, UPD_EVICT: begin
                    tag_q[victim] <= up_tag;
                    rec_q[victim] <= up_bit;
                    vld_q[victim] <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
    parameter int TAG_W   = 20,
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [TAG_W-1:0]   lk_tag,
    input logic               en_way0,
    input logic               en_way1,
    input logic               up_valid,
    input logic [TAG_W-1:0]   up_tag,
    input logic               up_way,
    input logic               lk_hit,
    input logic [ENTRIES-1:0] vld_q,
    input logic               alloc,
    input logic [IDX_W-1:0]   ptr
);

    // R1 R2 R3 R4: at least one way is always enabled
    a_r4_some_way: assert property (@(posedge clk) disable iff (!rst_n)
        en_way0 || en_way1);

    // R4: a miss in the match array enables both ways
    a_r4_miss_both: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (en_way0 && en_way1));

    // R5 R10: a way just recorded is enabled for that tag on the next cycle
    a_r5_way0_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_way) |=> ((lk_tag != $past(up_tag)) || en_way0));

    a_r5_way1_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_way) |=> ((lk_tag != $past(up_tag)) || en_way1));

    // R8: reset empties the buffer
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (vld_q == '0));

    // R9: pointer steps by one, wrapping, on each allocation
    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (int'(ptr) == ((int'($past(ptr)) == ENTRIES - 1) ? 0 : int'($past(ptr)) + 1)));

    // R7 R9: pointer holds without allocation
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc |=> $stable(ptr));

    // R10: no update, no change to occupancy
    a_r10_no_update_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(vld_q));

endmodule

bind way_predictor wp_checker #(.TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_tag   (lk_tag),
    .en_way0  (en_way0),
    .en_way1  (en_way1),
    .up_valid (up_valid),
    .up_tag   (up_tag),
    .up_way   (up_way),
    .lk_hit   (lk_hit),
    .vld_q    (vld_q),
    .alloc    (alloc),
    .ptr      (alloc_ptr)
);

// File: tb/way_predictor_tb.sv
`timescale 1ns/1ps
module way_predictor_tb;

    localparam int TW = 20;
    localparam int NE = 8;

    logic          clk      = 1'b0;
    logic          rst_n    = 1'b0;
    logic [TW-1:0] lk_tag   = '0;
    logic          up_valid = 1'b0;
    logic [TW-1:0] up_tag   = '0;
    logic          up_way   = 1'b0;
    logic          en_way0;
    logic          en_way1;

    always #2.5 clk = ~clk;

    way_predictor #(.TAG_W(TW), .ENTRIES(NE)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_tag   (lk_tag),
        .en_way0  (en_way0),
        .en_way1  (en_way1),
        .up_valid (up_valid),
        .up_tag   (up_tag),
        .up_way   (up_way)
    );

    typedef struct {
        logic  e0;
        logic  e1;
        string req;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // reference model of the buffer
    logic [TW-1:0] m_tag [NE];
    logic [1:0]    m_rec [NE];
    bit            m_vld [NE];
    int            m_ptr;

    function automatic int m_find(input logic [TW-1:0] t);
        for (int i = 0; i < NE; i++) begin
            if (m_vld[i] && m_tag[i] == t) return i;
        end
        return -1;
    endfunction

    function automatic void m_clear();
        for (int i = 0; i < NE; i++) m_vld[i] = 0;
        m_ptr = 0;
    endfunction

    function automatic void m_update(input logic [TW-1:0] t, input bit w);
        int k;
        logic [1:0] b;
        b = w ? 2'b01 : 2'b10;
        k = m_find(t);
        if (k >= 0) begin
            m_rec[k] = m_rec[k] | b;
        end else begin
            k = -1;
            for (int i = 0; i < NE; i++) begin
                if (!m_vld[i] && k < 0) k = i;
            end
            if (k < 0) k = m_ptr;
            m_tag[k] = t;
            m_rec[k] = b;
            m_vld[k] = 1;
            m_ptr    = (m_ptr + 1) % NE;
        end
    endfunction

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic step(input logic [TW-1:0] lt, input bit uv,
                        input logic [TW-1:0] ut, input bit uw, input string req);
        exp_t e;
        int   k;
        @(posedge clk);
        #1;
        lk_tag   = lt;
        up_valid = uv;
        up_tag   = ut;
        up_way   = uw;
        k = m_find(lt);
        if (k < 0) begin
            e.e0 = 1'b1;
            e.e1 = 1'b1;
        end else begin
            e.e0 = m_rec[k][1];
            e.e1 = m_rec[k][0];
        end
        if (req != "") e.req = req;
        else if (k < 0) e.req = "R4";
        else if (m_rec[k] == 2'b10) e.req = "R1";
        else if (m_rec[k] == 2'b01) e.req = "R2";
        else e.req = "R3";
        sbq.push_back(e);
        if (uv && rst_n) m_update(ut, uw);
    endtask

    task automatic look(input logic [TW-1:0] lt, input string req);
        step(lt, 1'b0, '0, 1'b0, req);
    endtask

    task automatic put(input logic [TW-1:0] ut, input bit uw);
        step(ut + 20'h80000, 1'b1, ut, uw, "R4");
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n    = 1'b0;
        up_valid = 1'b0;
        repeat (2) @(posedge clk);
        m_clear();
        // R8: buffer empty while reset is held
        look(20'h00100, "R8");
        look(20'h00103, "R8");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // monitor: compare outputs mid-cycle
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (en_way0 !== e.e0 || en_way1 !== e.e1) begin
                errors++;
                $display("FAIL %s: actual en_way0=%b en_way1=%b expected en_way0=%b en_way1=%b (lk_tag=%h)",
                         e.req, en_way0, en_way1, e.e0, e.e1, lk_tag);
            end
        end
    end

    initial begin
        m_clear();
        do_reset();

        // R8: after release everything misses
        look(20'h00100, "R8");

        // R10: allocation in the same cycle as a lookup of that tag
        step(20'h00100, 1'b1, 20'h00100, 1'b0, "R10");
        look(20'h00100, "R5");   // R5 and R1: only way 0
        look(20'h00100, "R1");

        put(20'h00101, 1'b1);
        look(20'h00101, "R2");

        // R10: merge in the same cycle as a lookup of that tag
        step(20'h00100, 1'b1, 20'h00100, 1'b1, "R10");
        look(20'h00100, "R6");   // R6 and R3: both ways
        look(20'h00100, "R3");

        // R7: redundant update
        put(20'h00101, 1'b1);
        look(20'h00101, "R7");

        // fill the remaining six entries
        for (int i = 2; i < NE; i++) put(20'h00100 + i, 1'b0);
        look(20'h00107, "R9");

        // R9: buffer full, pointer back to entry 0
        put(20'h00108, 1'b1);
        look(20'h00100, "R9");
        look(20'h00108, "R9");
        put(20'h00109, 1'b0);
        look(20'h00101, "R9");
        look(20'h00102, "R9");

        // R7: a repeated update must not move the pointer
        put(20'h00109, 1'b0);
        put(20'h0010a, 1'b0);
        look(20'h00102, "R7");
        look(20'h00103, "R7");

        // R8: mid-run reset clears everything
        do_reset();
        look(20'h00103, "R8");
        look(20'h00109, "R8");

        // mixed traffic over a small tag pool
        for (int i = 0; i < 400; i++) begin
            step(TW'(20'h00300 + $urandom_range(0, 11)), 1'($urandom_range(0, 1)),
                 TW'(20'h00300 + $urandom_range(0, 11)), 1'($urandom_range(0, 1)), "");
        end

        @(posedge clk);
        #1;
        up_valid = 1'b0;
        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule